// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit handles data hazards in a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it receives the register fields of the instruction leaving decode. It keeps its own shadow of the execute, memory and write-back stage entries, and advances that shadow in step with the pipeline. From the shadow it drives two operand-select codes for the instruction now in execute. Each code picks the register-file value, the write-back value or the memory-stage value for one ALU input.

A load in execute is a problem when the instruction in decode reads that load's destination. In that case the unit raises a hold request for the program counter and the fetch/decode register. In the same cycle it asks for a bubble in the decode/execute register, and it loads a no-op into its own execute entry. The held instruction advances one cycle later. It then picks up the loaded data from write-back through the bypass path.

A dependency at distance three needs no bypass. The register file writes in the first half of a cycle and reads in the second half, so the value is already in place.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is asserted and right after it, `stall_o` and `bubble_o` are 0 and both selects are 00.
- R2: Each select is 2 bits with this encoding: 00 = register file, 01 = write-back value, 10 = memory-stage value; 11 never appears. A source of the execute instruction equal to the destination of a writing memory-stage entry (the previous instruction) selects 10.
- R3: A source that matches only a writing write-back entry (two instructions earlier) selects 01.
- R4: When the memory-stage and write-back entries both match a source, the memory-stage value (10) wins.
- R5: Register 0 never causes a bypass or a stall, even when an entry names it as its destination.
- R6: An entry whose write enable is low (store, branch) never drives a select away from 00.
- R7: A load in execute whose nonzero destination equals either source of a valid decode instruction raises `stall_o` and `bubble_o` for exactly one cycle. The execute entry that follows is a no-op that writes nothing and reads nothing.
- R8: After such a stall, the held consumer reaches execute with the load in write-back and selects 01 for the dependent source.
- R9: A load followed by an instruction that does not read its destination causes no stall.
- R10: A producer three instructions ahead of a consumer causes no bypass (select 00).
- R11: Back-to-back ALU dependencies at distance one and two never cause a stall.
- R12: A decode slot with `dec_valid_i` low enters execute as a no-op: it never causes a bypass or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decode slot holds a real instruction |
| dec_src_a_i | input | REG_W | First source register of the decode instruction |
| dec_src_b_i | input | REG_W | Second source register of the decode instruction |
| dec_dst_i | input | REG_W | Destination register of the decode instruction |
| dec_reg_we_i | input | 1 | Decode instruction writes a register |
| dec_mem_rd_i | input | 1 | Decode instruction is a load |
| fwd_sel_a_o | output | 2 | Operand select for ALU input A of the execute instruction |
| fwd_sel_b_o | output | 2 | Operand select for ALU input B of the execute instruction |
| stall_o | output | 1 | Hold the program counter and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op into the decode/execute register |

## Verification
The hardest case to reach is the one after a stall. The consumer has been held in decode, and a bubble now sits between it and the load. Only one ordering gives the write-back bypass from a load. The stimulus gets there by modelling the fetch side: while the expected stall is high, it presents the same decode instruction again, as a real front end would. Random instruction streams drawn from only four register numbers make loads, distance-one and distance-two producers, and register 0 collide often. Directed sequences add the double-match priority case, the distance-three case and the invalid-slot case.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hazard_stage_pipe.sv
module hazard_stage_pipe #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            dec_valid_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   dec_src_i,
  input  logic [REG_W-1:0]                dec_dst_i,
  input  logic                            dec_reg_we_i,
  input  logic                            dec_mem_rd_i,
  input  logic                            bubble_i,
  output logic [NUM_SRC-1:0][REG_W-1:0]   ex_src_o,
  output logic [REG_W-1:0]                ex_dst_o,
  output logic                            ex_we_o,
  output logic                            ex_mrd_o,
  output logic [REG_W-1:0]                mem_dst_o,
  output logic                            mem_we_o,
  output logic [REG_W-1:0]                wb_dst_o,
  output logic                            wb_we_o
);
  // tail stages after execute: memory, write-back
  localparam int NUM_TAIL = 2;

  logic                 take_dec;
  logic [REG_W-1:0]     tail_dst [NUM_TAIL+1];
  logic                 tail_we  [NUM_TAIL+1];

  assign take_dec = dec_valid_i && !bubble_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_src_o <= '0;
      ex_dst_o <= '0;
      ex_we_o  <= 1'b0;
      ex_mrd_o <= 1'b0;
    end else if (take_dec) begin
      ex_src_o <= dec_src_i;
      ex_dst_o <= dec_dst_i;
      ex_we_o  <= dec_reg_we_i;
      ex_mrd_o <= dec_mem_rd_i;
    end else begin
      ex_src_o <= '0;
      ex_dst_o <= '0;
      ex_we_o  <= 1'b0;
      ex_mrd_o <= 1'b0;
    end
  end

  assign tail_dst[0] = ex_dst_o;
  assign tail_we[0]  = ex_we_o;

  for (genvar s = 1; s <= NUM_TAIL; s++) begin : g_tail
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tail_dst[s] <= '0;
        tail_we[s]  <= 1'b0;
      end else begin
        tail_dst[s] <= tail_dst[s-1];
        tail_we[s]  <= tail_we[s-1];
      end
    end
  end

  assign mem_dst_o = tail_dst[1];
  assign mem_we_o  = tail_we[1];
  assign wb_dst_o  = tail_dst[2];
  assign wb_we_o   = tail_we[2];

  assert_bubble_inert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i |=> (!ex_we_o && !ex_mrd_o && ex_src_o == '0));

  assert_invalid_inert_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> (!ex_we_o && !ex_mrd_o));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !bubble_i) |=> (ex_dst_o == $past(dec_dst_i)));
endmodule

// File: rtl/hazard_fwd_sel.sv
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic src_live, mem_hit, wb_hit;

  assign src_live = (src_i != '0);
  assign mem_hit  = src_live && mem_we_i && (mem_dst_i == src_i);
  assign wb_hit   = src_live && wb_we_i  && (wb_dst_i  == src_i);

  // younger producer first
  always_comb begin
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end

  assert_sel_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b11);

  assert_zero_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != SEL_RF) |-> (src_i != '0));

  assert_wb_needs_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == SEL_WB) |-> wb_we_i);

  assert_mem_needs_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == SEL_MEM) |-> mem_we_i);
endmodule

// File: rtl/hazard_load_check.sv
module hazard_load_check #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          dec_valid_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src_i,
  input  logic [REG_W-1:0]              ex_dst_i,
  input  logic                          ex_we_i,
  input  logic                          ex_mrd_i,
  output logic                          hit_o
);
  logic [NUM_SRC-1:0] src_match;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign src_match[i] = (dec_src_i[i] == ex_dst_i);
  end

  assign hit_o = dec_valid_i && ex_we_i && ex_mrd_i &&
                 (ex_dst_i != '0) && (|src_match);

  assert_hit_is_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ex_mrd_i && ex_we_i));

  assert_hit_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ex_dst_i != '0));
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [REG_W-1:0] dec_src_a_i,
  input  logic [REG_W-1:0] dec_src_b_i,
  input  logic [REG_W-1:0] dec_dst_i,
  input  logic             dec_reg_we_i,
  input  logic             dec_mem_rd_i,
  output logic [1:0]       fwd_sel_a_o,
  output logic [1:0]       fwd_sel_b_o,
  output logic             stall_o,
  output logic             bubble_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] dec_src, ex_src;
  logic [REG_W-1:0]              ex_dst, mem_dst, wb_dst;
  logic                          ex_we, ex_mrd, mem_we, wb_we;
  logic                          load_hit;
  fwd_sel_e                      sel [NUM_SRC];

  assign dec_src[0] = dec_src_a_i;
  assign dec_src[1] = dec_src_b_i;

  hazard_load_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_load_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_valid_i (dec_valid_i),
    .dec_src_i   (dec_src),
    .ex_dst_i    (ex_dst),
    .ex_we_i     (ex_we),
    .ex_mrd_i    (ex_mrd),
    .hit_o       (load_hit)
  );

  hazard_stage_pipe #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_stage_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dec_valid_i  (dec_valid_i),
    .dec_src_i    (dec_src),
    .dec_dst_i    (dec_dst_i),
    .dec_reg_we_i (dec_reg_we_i),
    .dec_mem_rd_i (dec_mem_rd_i),
    .bubble_i     (load_hit),
    .ex_src_o     (ex_src),
    .ex_dst_o     (ex_dst),
    .ex_we_o      (ex_we),
    .ex_mrd_o     (ex_mrd),
    .mem_dst_o    (mem_dst),
    .mem_we_o     (mem_we),
    .wb_dst_o     (wb_dst),
    .wb_we_o      (wb_we)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    hazard_fwd_sel #(.REG_W(REG_W)) i_fwd_sel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (ex_src[i]),
      .mem_dst_i (mem_dst),
      .mem_we_i  (mem_we),
      .wb_dst_i  (wb_dst),
      .wb_we_i   (wb_we),
      .sel_o     (sel[i])
    );
  end

  assign fwd_sel_a_o = sel[0];
  assign fwd_sel_b_o = sel[1];
  assign stall_o     = load_hit;
  assign bubble_o    = load_hit;

  assert_single_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  assert_load_lands_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !(mem_we && ex_src == '0 && ex_we));
endmodule

// File: tb/test_fwd_hazard_unit.sv
`timescale 1ns/1ps
module test_fwd_hazard_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dec_valid_i = 1'b0;
  logic [4:0] dec_src_a_i = '0, dec_src_b_i = '0, dec_dst_i = '0;
  logic       dec_reg_we_i = 1'b0, dec_mem_rd_i = 1'b0;
  logic [1:0] fwd_sel_a_o, fwd_sel_b_o;
  logic       stall_o, bubble_o;

  fwd_hazard_unit i_fwd_hazard_unit (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    bit v; logic [4:0] a, b, d; bit we, mr; int why; // why: 0 live, 1 invalid, 2 squashed
  } ent_t;

  ent_t ex_m, mem_m, wb_m, nop_e;
  int   n_chk = 0, n_err = 0;
  bit   last_stall = 0, done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit live_wr(ent_t e, logic [4:0] r);
    return e.why == 0 && e.we && r != 0 && e.d == r;
  endfunction

  function automatic int exp_sel(logic [4:0] s);
    if (ex_m.why != 0 || s == 0) return 0;
    if (live_wr(mem_m, s)) return 2;
    if (live_wr(wb_m, s)) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(logic [4:0] s, int e);
    if (ex_m.why != 0) return "R7";
    if (e == 2) return live_wr(wb_m, s) ? "R4" : "R2";
    if (e == 1) return wb_m.mr ? "R8" : "R3";
    if (s == 0) return "R5";
    if ((mem_m.d == s && mem_m.why == 1) || (wb_m.d == s && wb_m.why == 1)) return "R12";
    if ((mem_m.d == s && mem_m.why == 2) || (wb_m.d == s && wb_m.why == 2)) return "R7";
    if ((mem_m.d == s && !mem_m.we) || (wb_m.d == s && !wb_m.we)) return "R6";
    return "R10";
  endfunction

  task automatic present(input ent_t i);
    bit    es;
    int    ea, eb;
    string st;
    @(negedge clk_i);
    dec_valid_i = i.v; dec_src_a_i = i.a; dec_src_b_i = i.b;
    dec_dst_i = i.d; dec_reg_we_i = i.we; dec_mem_rd_i = i.mr;
    #1;
    es = i.v && ex_m.why == 0 && ex_m.we && ex_m.mr && ex_m.d != 0 &&
         (ex_m.d == i.a || ex_m.d == i.b);
    if (es) st = "R7";
    else if (ex_m.why == 0 && ex_m.we && ex_m.mr && ex_m.d == 0 && i.v && (i.a == 0 || i.b == 0)) st = "R5";
    else if (ex_m.why == 0 && ex_m.mr) st = "R9";
    else if (!i.v) st = "R12";
    else st = "R11";
    check(st, stall_o, es);
    check(st, bubble_o, es);
    ea = exp_sel(ex_m.a); eb = exp_sel(ex_m.b);
    check(sel_tag(ex_m.a, ea), fwd_sel_a_o, ea);
    check(sel_tag(ex_m.b, eb), fwd_sel_b_o, eb);
    wb_m = mem_m; mem_m = ex_m;
    ex_m = i;
    ex_m.why = es ? 2 : (!i.v ? 1 : 0);
    last_stall = es;
  endtask

  function automatic ent_t mk(bit v, int a, int b, int d, bit we, bit mr);
    ent_t e;
    e.v = v; e.a = 5'(a); e.b = 5'(b); e.d = 5'(d); e.we = we; e.mr = mr; e.why = 0;
    return e;
  endfunction

  task automatic issue(input ent_t i);
    present(i);
    while (last_stall) present(i);
  endtask

  task automatic flush();
    for (int k = 0; k < 3; k++) issue(nop_e);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    nop_e = mk(0, 0, 0, 0, 0, 0); nop_e.why = 1;
    ex_m = nop_e; mem_m = nop_e; wb_m = nop_e;
    #10;
    check("R1", stall_o, 0); check("R1", bubble_o, 0);
    check("R1", fwd_sel_a_o, 0); check("R1", fwd_sel_b_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R2 distance one, R3 distance two, R11 no stall
    issue(mk(1, 2, 3, 1, 1, 0)); issue(mk(1, 1, 4, 5, 1, 0)); issue(mk(1, 4, 1, 6, 1, 0)); flush();
    // R4 both match
    issue(mk(1, 0, 0, 7, 1, 0)); issue(mk(1, 0, 0, 7, 1, 0)); issue(mk(1, 7, 7, 8, 1, 0)); flush();
    // R5 register 0 producer and load
    issue(mk(1, 0, 0, 0, 1, 0)); issue(mk(1, 0, 0, 0, 1, 1)); issue(mk(1, 0, 0, 9, 1, 0)); flush();
    // R6 store/branch producer
    issue(mk(1, 3, 4, 10, 0, 0)); issue(mk(1, 10, 10, 11, 1, 0)); flush();
    // R7/R8 load-use
    issue(mk(1, 1, 0, 12, 1, 1)); issue(mk(1, 12, 2, 13, 1, 0)); issue(nop_e); flush();
    // R9 load then unrelated
    issue(mk(1, 1, 0, 14, 1, 1)); issue(mk(1, 2, 3, 15, 1, 0)); flush();
    // R10 distance three
    issue(mk(1, 0, 0, 16, 1, 0)); issue(mk(1, 1, 2, 17, 1, 0)); issue(mk(1, 1, 2, 18, 1, 0));
    issue(mk(1, 16, 16, 19, 1, 0)); flush();
    // R12 invalid slot carrying a destination
    issue(mk(0, 0, 0, 20, 1, 1)); issue(mk(1, 20, 20, 21, 1, 0)); flush();
    // random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 2000; n++) begin
      ent_t r;
      r = mk($urandom_range(0, 9) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 3) != 0, 0);
      r.mr = r.we && ($urandom_range(0, 2) == 0);
      issue(r);
    end
    flush();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule